// File: doc/BRIEF.md
# Parallel Priority Bus Arbiter

This block shares one system bus among eight masters. Each master has a local controller. When its host wants a transfer, the controller pulls an active-low request line low. A central resolver turns the set of active requests into a single active-low grant for the highest-priority requester. It is built as a priority encoder that produces a binary index, followed by a one-of-N decoder.

A grant alone does not hand over the bus. A granted controller takes ownership only on a clock edge where the shared active-low busy line is also released. It then holds busy low until its transfer-done strobe. Busy is the wired-AND of the per-master busy drives. Normally ownership ends on the first done strobe, so lower-priority masters get their turn. While the host holds the lock input, done strobes do not end ownership. A read-then-write pair therefore stays indivisible, even when a higher-priority master is requesting.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is high, and in the cycle after it falls, every request line, every grant line and the busy line are high (released), and no owner flag is set.
- R2: A master whose want input is high while it is idle drives its request line low from the next cycle. It holds it low until the cycle after its last transfer ends.
- R3: Grant line i is low only when request line i is low and no request line with a smaller index is low. Index 0 has the highest priority. With no request low, all grant lines are high.
- R4: A master takes ownership on a clock edge where its grant is low and busy is high. From the next cycle, its owner flag is set and busy reads low.
- R5: A granted master that sees busy low does not take the bus. It takes it on the first edge where it is still granted and busy is high.
- R6: When an owner sees done high and lock low, in the next cycle its owner flag clears, busy is released and its request line goes high. One cycle later it is idle again.
- R7: When an owner sees done high while lock is high, it keeps ownership and busy stays low. Lowering lock without a done strobe also keeps ownership. The first done strobe with lock low ends ownership.
- R8: A higher-priority master that requests while another master owns the bus receives the grant. It does not own the bus while busy is held low.
- R9: At most one owner flag is set at any time. Busy is low exactly when some master owns the bus.
- R10: A done strobe to a master that does not own the bus changes no owner flag, request line or busy level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| want_i | input | 8 | Per-master wish to perform a transfer |
| lock_i | input | 8 | Per-master hold-ownership request |
| done_i | input | 8 | Per-master transfer-complete strobe |
| breq_n_o | output | 8 | Per-master active-low bus request |
| bprn_n_o | output | 8 | Per-master active-low priority grant |
| busy_n_o | output | 1 | Shared active-low bus busy (wired-AND) |
| own_o | output | 8 | Per-master ownership flag |

## Verification
The hardest state to reach is a higher-priority master that holds the grant while a locked lower-priority owner keeps busy low. The bench gives master 3 the bus with lock high and then raises master 1's request. It strobes done while lock is still high, and later lowers lock without a strobe. It checks that master 1 stays granted but not owning until the final unlocked done, and that master 1 takes the bus on the very next edge. A table of request patterns also checks which master takes the bus first and which master holds the grant once the first owner releases.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    localparam int ARB_MASTERS = 8;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_REQUEST   = 3'd1,
        ST_WAIT_IDLE = 3'd2,
        ST_OWN       = 3'd3,
        ST_RELEASE   = 3'd4
    } acq_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/prio_encoder.sv
module prio_encoder #(
    parameter int N     = bus_arb_pkg::ARB_MASTERS,
    parameter int IDX_W = bus_arb_pkg::idx_width(N)
) (
    input  logic [N-1:0]     req_n_i,
    output logic [IDX_W-1:0] code_o,
    output logic             valid_o
);
    always_comb begin
        code_o  = '0;
        valid_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!req_n_i[i]) begin
                code_o  = IDX_W'(i);
                valid_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/grant_decoder.sv
module grant_decoder #(
    parameter int N     = bus_arb_pkg::ARB_MASTERS,
    parameter int IDX_W = bus_arb_pkg::idx_width(N)
) (
    input  logic [IDX_W-1:0] code_i,
    input  logic             valid_i,
    output logic [N-1:0]     grant_n_o
);
    for (genvar g = 0; g < N; g++) begin : g_line
        assign grant_n_o[g] = !(valid_i && (code_i == IDX_W'(g)));
    end
endmodule

// File: rtl/master_ctrl.sv
module master_ctrl
    import bus_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic want_i,
    input  logic lock_i,
    input  logic done_i,
    input  logic grant_n_i,
    input  logic busy_n_i,
    output logic breq_n_o,
    output logic busy_drv_n_o,
    output logic own_o
);
    acq_state_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (want_i) st <= ST_REQUEST;
                end
                ST_REQUEST, ST_WAIT_IDLE: begin
                    if (!grant_n_i && busy_n_i) st <= ST_OWN;
                    else if (!grant_n_i)        st <= ST_WAIT_IDLE;
                    else                        st <= ST_REQUEST;
                end
                ST_OWN: begin
                    if (done_i && !lock_i) st <= ST_RELEASE;
                end
                ST_RELEASE: st <= ST_IDLE;
                default:    st <= ST_IDLE;
            endcase
        end
    end

    assign own_o        = (st == ST_OWN);
    assign busy_drv_n_o = !(st == ST_OWN);
    assign breq_n_o     = !(st == ST_REQUEST || st == ST_WAIT_IDLE || st == ST_OWN);

    AST_TAKE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(own_o) |-> $past(!grant_n_i && busy_n_i)); // R5
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (own_o && lock_i) |=> own_o); // R7
    AST_UNLOCK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (own_o && done_i && !lock_i) |=> (!own_o && breq_n_o && busy_drv_n_o)); // R6
    AST_NOT_OWNER_DONE: assert property (@(posedge clk) disable iff (rst)
        (!own_o && busy_drv_n_o) |=> (!own_o || $past(!grant_n_i))); // R10
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
    parameter int N = bus_arb_pkg::ARB_MASTERS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] want_i,
    input  logic [N-1:0] lock_i,
    input  logic [N-1:0] done_i,
    output logic [N-1:0] breq_n_o,
    output logic [N-1:0] bprn_n_o,
    output logic         busy_n_o,
    output logic [N-1:0] own_o
);
    localparam int IDX_W = bus_arb_pkg::idx_width(N);

    logic [IDX_W-1:0] win_code;
    logic             win_valid;
    logic [N-1:0]     busy_drv_n;

    prio_encoder #(.N(N), .IDX_W(IDX_W)) u_enc (
        .req_n_i (breq_n_o),
        .code_o  (win_code),
        .valid_o (win_valid)
    );

    grant_decoder #(.N(N), .IDX_W(IDX_W)) u_dec (
        .code_i    (win_code),
        .valid_i   (win_valid),
        .grant_n_o (bprn_n_o)
    );

    for (genvar m = 0; m < N; m++) begin : g_master
        master_ctrl u_ctrl (
            .clk          (clk),
            .rst          (rst),
            .want_i       (want_i[m]),
            .lock_i       (lock_i[m]),
            .done_i       (done_i[m]),
            .grant_n_i    (bprn_n_o[m]),
            .busy_n_i     (busy_n_o),
            .breq_n_o     (breq_n_o[m]),
            .busy_drv_n_o (busy_drv_n[m]),
            .own_o        (own_o[m])
        );
    end

    assign busy_n_o = &busy_drv_n;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bprn_n_o)); // R3
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        ((~bprn_n_o) & breq_n_o) == '0); // R3
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(own_o)); // R9
    AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (rst)
        busy_n_o == (own_o == '0)); // R9
endmodule

// File: tb/bus_arbiter_tb.sv
module bus_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] want = '0, lock = '0, done = '0;
    logic [7:0] breq_n, bprn_n, own;
    logic       busy_n;
    int         n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    bus_arbiter u_dut (
        .clk (clk), .rst (rst), .want_i (want), .lock_i (lock), .done_i (done),
        .breq_n_o (breq_n), .bprn_n_o (bprn_n), .busy_n_o (busy_n), .own_o (own)
    );

    // {request pattern, first owner index, next grant index (15 = none)}
    localparam logic [15:0] VEC [6] = '{
        16'h01_0F, 16'h80_7F, 16'hFF_01, 16'hA4_25, 16'h60_56, 16'h82_17
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gnt_n(input logic [3:0] idx);
        return (idx == 4'hF) ? 8'hFF : ~(8'h01 << idx);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; want = '0; lock = '0; done = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        chk(breq_n == 8'hFF && bprn_n == 8'hFF, "R1", {breq_n, bprn_n}, 16'hFFFF);
        chk(busy_n == 1'b1 && own == '0, "R1", {busy_n, own}, 9'h100);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_n == 1'b1 && own == '0 && breq_n == 8'hFF, "R1", {busy_n, own}, 9'h100);

        // table walk: first owner and next grant per request pattern
        for (int k = 0; k < 6; k++) begin
            logic [7:0] pat, first_oh;
            logic [3:0] first, second;
            pat = VEC[k][15:8]; first = VEC[k][7:4]; second = VEC[k][3:0];
            first_oh = 8'h01 << first;
            do_reset();
            want = pat;
            @(negedge clk);
            chk(breq_n == ~pat, "R2", breq_n, ~pat);
            chk(bprn_n == gnt_n(first), "R3", bprn_n, gnt_n(first));
            chk(own == '0 && busy_n, "R4", {busy_n, own}, 9'h100);
            @(negedge clk);
            chk(own == first_oh, "R4", own, first_oh);
            chk(busy_n == 1'b0, "R9", busy_n, 1'b0);
            done = first_oh; want = '0;
            @(negedge clk);
            done = '0;
            chk(own == '0 && busy_n, "R6", {busy_n, own}, 9'h100);
            chk(breq_n == ~(pat & ~first_oh), "R6", breq_n, ~(pat & ~first_oh));
            chk(bprn_n == gnt_n(second), "R3", bprn_n, gnt_n(second));
        end

        // locked owner, higher-priority request, late release
        do_reset();
        want = 8'h08; lock = 8'h08;
        repeat (2) @(negedge clk);
        chk(own == 8'h08, "R4", own, 8'h08);
        want = 8'h0A; done = 8'h08;
        @(negedge clk);
        done = '0;
        chk(own == 8'h08 && !busy_n, "R7", {busy_n, own}, 9'h008);
        chk(bprn_n == 8'hFD, "R8", bprn_n, 8'hFD);
        @(negedge clk);
        chk(own == 8'h08 && breq_n == 8'hF5, "R8", {breq_n, own}, 16'hF508);
        lock = '0;
        @(negedge clk);
        chk(own == 8'h08, "R7", own, 8'h08);
        done = 8'h08; want = 8'h02;
        @(negedge clk);
        done = '0;
        chk(own == '0 && busy_n, "R7", {busy_n, own}, 9'h100);
        @(negedge clk);
        chk(own == 8'h02 && !busy_n, "R5", {busy_n, own}, 9'h002);
        // done strobes to non-owners
        done = 8'h28; want = '0;
        @(negedge clk);
        done = '0;
        chk(own == 8'h02 && !busy_n && breq_n == 8'hFD, "R10", {breq_n, own}, 16'hFD02);
        done = 8'h02;
        @(negedge clk);
        done = '0;
        chk(own == '0 && breq_n == 8'hFF && busy_n, "R6", {breq_n, own}, 16'hFF00);
        @(negedge clk);
        chk(bprn_n == 8'hFF, "R3", bprn_n, 8'hFF);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule